// File: doc/BRIEF.md
# Register Protection Checker

This block guards a register bus. It holds a small table of protection entries. Each entry covers a naturally aligned, power-of-two run of register indices. An entry either stops writes only, or stops both reads and writes. Every cycle an access is presented as an 18-bit register index and a direction flag. One clock edge later, the block reports whether that access is refused and which table slot refused it.

Software loads the table one 32-bit word at a time through an address / data / write-enable configuration port. Each word carries three things: a base index, the base-2 logarithm of the range length, and two control bits. The block does not reject a base that is not a multiple of the length. It clears the low bits of that base instead, so the range that is actually guarded can differ from the range that was intended. When several slots refuse an access, the slot with the smallest number is reported.

Top module: `regprot_guard`

## Requirements
- R1: While reset is held and right after it, `prot_blocked` and `prot_entry` are 0 and every slot is empty, so no access is refused until a slot is written.
- R2: When `cfg_we` is high at a rising edge, slot `cfg_addr` is replaced by `cfg_wdata`. Accesses presented after that edge are judged against the new contents, and the old contents no longer have any effect.
- R3: The register base of a slot is word bits 19:2, an 18-bit index. Word bits 1:0 are ignored.
- R4: Word bits 28:24 hold L, the log2 of the range length. The slot covers 2^L indices. Any L of 18 or more covers the whole 18-bit index space.
- R5: A base that is not a multiple of 2^L is aligned down by clearing its low L bits. For example, base 0x07 with L=2 covers 0x04 to 0x07, and index 0x08 is not covered.
- R6: A slot with bit 29 set and bit 30 clear refuses writes in its range and lets reads through.
- R7: A slot with both bit 29 and bit 30 set refuses reads and writes in its range.
- R8: A slot with bit 29 clear is disabled and refuses nothing. This includes a slot that has only bit 30 set.
- R9: When several slots refuse an access, `prot_entry` gives the lowest-numbered one. When no slot refuses the access, `prot_entry` is 0.
- R10: The verdict on an access presented before a rising edge appears on `prot_blocked` and `prot_entry` after that edge, and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the protection table |
| cfg_addr | input | 3 | Slot number to write |
| cfg_wdata | input | 32 | Slot contents |
| acc_idx | input | 18 | Register index of the access being judged |
| acc_write | input | 1 | 1 for a write access, 0 for a read access |
| prot_blocked | output | 1 | Registered: the previous access was refused |
| prot_entry | output | 3 | Registered: lowest slot that refused it, 0 if none |

## Verification
The checker watches the following on every cycle:
- Each registered verdict matches the per-slot hit vector of the cycle before.
- The reported slot is the lowest set bit of that vector, and it is zero when nothing hit.
- A disabled slot never hits.
- A slot without the read bit never hits a read.
- A configuration write lands in the addressed slot.

Range coverage needs the bench's scenarios to show it: the alignment of misaligned bases, the whole-space sizes, and overlap priority. The bench sweeps indices and directions against a shift-based model of the covered range.

// File: rtl/regprot_pkg.sv
package regprot_pkg;

  localparam int IDX_W   = 18;
  localparam int LG_W    = 5;
  localparam int WORD_W  = 32;
  localparam int BASE_LO = 2;
  localparam int BASE_HI = BASE_LO + IDX_W - 1;
  localparam int LG_LO   = 24;
  localparam int LG_HI   = LG_LO + LG_W - 1;
  localparam int WR_BIT  = 29;
  localparam int RD_BIT  = 30;

  typedef struct packed {
    logic            rd_blk;
    logic            wr_blk;
    logic [LG_W-1:0] lg;
    logic [IDX_W-1:0] base;
  } prot_ent_t;

  function automatic prot_ent_t unpack_word(logic [WORD_W-1:0] w);
    prot_ent_t e;
    e.rd_blk = w[RD_BIT];
    e.wr_blk = w[WR_BIT];
    e.lg     = w[LG_HI:LG_LO];
    e.base   = w[BASE_HI:BASE_LO];
    return e;
  endfunction

  // bits at or above lg compare; lg >= IDX_W leaves nothing to compare
  function automatic logic [IDX_W-1:0] span_mask(logic [LG_W-1:0] lg);
    logic [IDX_W-1:0] m;
    for (int b = 0; b < IDX_W; b++) m[b] = (LG_W'(b) >= lg);
    return m;
  endfunction

  function automatic logic covers(prot_ent_t e, logic [IDX_W-1:0] idx);
    return ((idx ^ e.base) & span_mask(e.lg)) == '0;
  endfunction

  function automatic logic refuses(prot_ent_t e, logic is_wr);
    return e.wr_blk && (is_wr || e.rd_blk);
  endfunction

endpackage

// File: rtl/regprot_table.sv
module regprot_table
  import regprot_pkg::*;
#(
  parameter int N  = 8,
  parameter int AW = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [AW-1:0]       addr,
  input  logic [WORD_W-1:0]   wdata,
  output prot_ent_t [N-1:0]   ents_o
);

  prot_ent_t [N-1:0] slot_q;
  logic unused_word_bits;

  assign unused_word_bits = ^{wdata[WORD_W-1], wdata[LG_LO-1:BASE_HI+1], wdata[BASE_LO-1:0]};

  for (genvar i = 0; i < N; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_q[i] <= '0;
      end else if (we && (addr == AW'(i))) begin
        slot_q[i] <= unpack_word(wdata);
      end
    end
  end

  assign ents_o = slot_q;

endmodule

// File: rtl/regprot_slot.sv
module regprot_slot
  import regprot_pkg::*;
(
  input  prot_ent_t         ent,
  input  logic [IDX_W-1:0]  idx,
  input  logic              is_wr,
  output logic              cov_o,
  output logic              hit_o
);

  assign cov_o = covers(ent, idx);
  assign hit_o = cov_o && refuses(ent, is_wr);

endmodule

// File: rtl/regprot_pick.sv
module regprot_pick #(
  parameter int N  = 8,
  parameter int AW = 3
) (
  input  logic [N-1:0]  vec,
  output logic          any_o,
  output logic [AW-1:0] idx_o
);

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx_o = AW'(i);
    end
  end

  assign any_o = |vec;

endmodule

// File: rtl/regprot_guard.sv
module regprot_guard
  import regprot_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  localparam int AW = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic [IDX_W-1:0]  acc_idx,
  input  logic              acc_write,
  output logic              prot_blocked,
  output logic [AW-1:0]     prot_entry
);

  prot_ent_t [NUM_ENTRIES-1:0] ents;
  logic [NUM_ENTRIES-1:0]      hit_vec;
  logic [NUM_ENTRIES-1:0]      cov_vec;
  logic                        any_hit;
  logic [AW-1:0]               pick_idx;

  regprot_table #(.N(NUM_ENTRIES), .AW(AW)) u_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (cfg_we),
    .addr   (cfg_addr),
    .wdata  (cfg_wdata),
    .ents_o (ents)
  );

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_match
    regprot_slot u_slot (
      .ent   (ents[i]),
      .idx   (acc_idx),
      .is_wr (acc_write),
      .cov_o (cov_vec[i]),
      .hit_o (hit_vec[i])
    );
  end

  regprot_pick #(.N(NUM_ENTRIES), .AW(AW)) u_pick (
    .vec   (hit_vec),
    .any_o (any_hit),
    .idx_o (pick_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prot_blocked <= 1'b0;
      prot_entry   <= '0;
    end else begin
      prot_blocked <= any_hit;
      prot_entry   <= pick_idx;
    end
  end

  logic unused_cov;
  assign unused_cov = ^cov_vec;

endmodule

// File: rtl/regprot_guard_sva.sv
module regprot_guard_sva
  import regprot_pkg::*;
#(
  parameter int N  = 8,
  parameter int AW = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [AW-1:0]     cfg_addr,
  input logic [31:0]       cfg_wdata,
  input logic              acc_write,
  input prot_ent_t [N-1:0] ents,
  input logic [N-1:0]      hit_vec,
  input logic              prot_blocked,
  input logic [AW-1:0]     prot_entry
);

  logic [N-1:0]  prev_vec;
  logic          q_we;
  logic [AW-1:0] q_addr;
  logic [31:0]   q_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_vec <= '0;
      q_we     <= 1'b0;
      q_addr   <= '0;
      q_data   <= '0;
    end else begin
      prev_vec <= hit_vec;
      q_we     <= cfg_we;
      q_addr   <= cfg_addr;
      q_data   <= cfg_wdata;
    end
  end

  function automatic logic [N-1:0] below(logic [AW-1:0] k);
    logic [N-1:0] m;
    for (int b = 0; b < N; b++) m[b] = (AW'(b) < k);
    return m;
  endfunction

  // R10
  verdict_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot_blocked == (|prev_vec));

  // R9
  lowest_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot_blocked |-> (prev_vec[prot_entry] && ((prev_vec & below(prot_entry)) == '0)));

  // R9
  idle_slot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_blocked |-> (prot_entry == '0));

  // R2
  cfg_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_we && (int'(q_addr) < N)) |-> (ents[q_addr] == unpack_word(q_data)));

  for (genvar i = 0; i < N; i++) begin : g_slot_chk
    // R8
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ents[i].wr_blk |-> !hit_vec[i]);
    // R6
    read_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_write && !ents[i].rd_blk) |-> !hit_vec[i]);
  end

endmodule

bind regprot_guard regprot_guard_sva #(.N(NUM_ENTRIES), .AW(AW)) u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_we       (cfg_we),
  .cfg_addr     (cfg_addr),
  .cfg_wdata    (cfg_wdata),
  .acc_write    (acc_write),
  .ents         (ents),
  .hit_vec      (hit_vec),
  .prot_blocked (prot_blocked),
  .prot_entry   (prot_entry)
);

// File: tb/regprot_guard_tb.sv
`timescale 1ns/1ps
module regprot_guard_tb;

  localparam int N  = 8;
  localparam int AW = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [17:0] acc_idx = '0;
  logic        acc_write = 1'b0;
  logic        prot_blocked;
  logic [2:0]  prot_entry;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [31:0] mir [N];

  always #2 clk = ~clk;

  regprot_guard #(.NUM_ENTRIES(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .acc_idx(acc_idx), .acc_write(acc_write),
    .prot_blocked(prot_blocked), .prot_entry(prot_entry)
  );

  function automatic logic [31:0] word(int base, int lg, bit wr, bit rd);
    return {1'b0, rd, wr, 5'(lg), 4'b0, 18'(base), 2'b00};
  endfunction

  task automatic expect_for(input int idx, input bit wr, output bit eb, output int ee);
    eb = 1'b0; ee = 0;
    for (int e = N - 1; e >= 0; e--) begin
      int base = int'(mir[e][19:2]);
      int lg   = int'(mir[e][28:24]);
      bit cov  = (lg >= 18) ? 1'b1 : ((idx >> lg) == (base >> lg));
      bit act  = mir[e][29] && (wr || mir[e][30]);
      if (cov && act) begin eb = 1'b1; ee = e; end
    end
  endtask

  task automatic check(input string tag, input bit gb, input int ge, input bit eb, input int ee);
    checks++;
    if (gb !== eb || ge != ee) begin
      fails++;
      $display("FAIL %s: blocked=%0b entry=%0d expected blocked=%0b entry=%0d", tag, gb, ge, eb, ee);
    end
  endtask

  task automatic cfg_write(input int a, input logic [31:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = w;
    mir[a] = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic probe(input int idx, input bit wr, input string tag);
    bit eb; int ee;
    @(negedge clk);
    acc_idx = 18'(idx); acc_write = wr;
    @(negedge clk);
    expect_for(idx, wr, eb, ee);
    check(tag, prot_blocked, int'(prot_entry), eb, ee);
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < 64; i++) begin
      probe(i, 1'b0, tag);
      probe(i, 1'b1, tag);
    end
  endtask

  initial begin
    for (int e = 0; e < N; e++) mir[e] = '0;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check("R1", prot_blocked, int'(prot_entry), 1'b0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", prot_blocked, int'(prot_entry), 1'b0, 0);
    sweep("R1");

    // R5/R7: misaligned base 0x07, length 4 -> 0x04..0x07
    cfg_write(3, word(7, 2, 1, 1));
    probe(4, 1'b0, "R5");
    probe(8, 1'b0, "R5");
    probe(7, 1'b1, "R7");
    sweep("R5");

    // R6/R3: write-only slot, junk in word bits 1:0
    cfg_write(5, word(32'h20, 4, 1, 0) | 32'h3);
    probe(32'h20, 1'b0, "R6");
    probe(32'h2F, 1'b1, "R3");
    sweep("R6");

    // R9: overlapping lower-numbered slot
    cfg_write(1, word(32'h28, 3, 1, 1));
    probe(32'h2A, 1'b1, "R9");
    probe(32'h2A, 1'b0, "R9");
    sweep("R9");

    // R8: bit 30 only, and an all-zero-mode whole-space slot
    cfg_write(6, word(32'h10, 4, 0, 1));
    cfg_write(7, word(0, 31, 0, 0));
    probe(32'h12, 1'b1, "R8");
    probe(32'h3FFFF, 1'b0, "R8");
    sweep("R8");

    // R4: L=20 covers the whole index space
    cfg_write(0, word(0, 20, 1, 1));
    probe(32'h3FFFF, 1'b0, "R4");
    probe(32'h2ABCD, 1'b1, "R4");
    sweep("R4");

    // R10: latency of one edge
    cfg_write(0, 32'h0);
    probe(32'h30, 1'b0, "R10");
    @(negedge clk);
    acc_idx = 18'h4; acc_write = 1'b0;
    #1 check("R10", prot_blocked, int'(prot_entry), 1'b0, 0);
    @(negedge clk);
    check("R10", prot_blocked, int'(prot_entry), 1'b1, 3);

    // R2: overwrite replaces old contents
    cfg_write(3, word(32'h40, 2, 1, 1));
    probe(4, 1'b0, "R2");
    probe(32'h41, 1'b0, "R2");
    sweep("R2");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule